// File: doc/BRIEF.md
# Link Activity LED Blinker

This block drives the status LEDs of one Ethernet port. Both outputs are active low: a low level lights the LED. While the link-valid input is high and no traffic is seen, the link LED is lit continuously. A transmit or receive activity strobe darkens the LED for one fixed interval. The LED is then lit again for at least one interval of the same length before another dark pulse can start. Activity seen during a dark pulse or during the minimum lit time is remembered as a single pending flag. That flag produces exactly one further blink. Strobes are not counted one by one.

The interval length is a parameter in clock ticks, so a real 80 ms setting and a short setting for simulation use the same logic. A single down-counter times both the dark phase and the minimum lit phase. A second output lights the duplex LED while the link is up in full-duplex mode. Losing the link darkens the link LED at once, abandons any blink in progress and forgets pending activity. Reset is synchronous and active high.

Top module: `link_blink_led`

## Requirements
- R1: With the link up and no activity, `led_link_n_o` stays low (lit) on every cycle; a low level means lit on both LED outputs.
- R2: An activity strobe (`tx_act_i` or `rx_act_i` high) sampled while the link is up and idle sets `led_link_n_o` high from the next cycle for exactly `TICKS_PER_INTERVAL` cycles.
- R3: After each dark pulse, `led_link_n_o` is low for at least `TICKS_PER_INTERVAL` cycles before it can go high again.
- R4: Any number of strobes sampled during a dark pulse, or during the minimum lit time before its last cycle, produce exactly one further dark pulse, which starts right after the minimum lit time; with no such strobe the LED stays lit.
- R5: A strobe sampled in the last cycle of the minimum lit time starts the next dark pulse in the following cycle.
- R6: With `link_up_i` low, `led_link_n_o` is high from the next cycle; any blink in progress and any pending activity are dropped, so a link that returns shows a steady lit LED.
- R7: Activity strobes sampled while the link is down have no effect once the link returns.
- R8: `led_fdx_n_o` is low exactly one cycle after `link_up_i` and `fdx_i` are both sampled high, and high otherwise.
- R9: Synchronous reset `rst` drives both LED outputs high from the next edge and clears the pending flag; the block leaves reset with no link shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up_i | input | 1 | Link valid level |
| tx_act_i | input | 1 | Transmit activity strobe |
| rx_act_i | input | 1 | Receive activity strobe |
| fdx_i | input | 1 | Full-duplex status level |
| led_link_n_o | output | 1 | Link/activity LED, low = lit |
| led_fdx_n_o | output | 1 | Full-duplex LED, low = lit |

## Verification
Both LED outputs follow a state register. Each output therefore changes one clock edge after the input that causes it is sampled. A dark pulse then lasts exactly `TICKS_PER_INTERVAL` cycles, and so does the minimum lit phase after it. The bench changes inputs on the falling edge and checks on the next falling edge, so each expected value belongs to the rising edge in between. With a short interval of four ticks, the table of vectors lists the expected level for every cycle of the blink, hold and restart sequences. Directed tests then count the length of the dark and lit runs directly, and check that reset and link loss leave no pending blink behind.

// File: rtl/link_blink_pkg.sv
package link_blink_pkg;

  typedef enum logic [1:0] {
    ST_NO_LINK   = 2'd0,
    ST_LINK_IDLE = 2'd1,
    ST_BLINK_OFF = 2'd2,
    ST_HOLD_ON   = 2'd3
  } led_state_e;

  // Counter width able to hold ticks-1.
  function automatic int cnt_width(input int ticks);
    return (ticks <= 2) ? 1 : $clog2(ticks);
  endfunction

  // High (dark) in every state except the two lit ones.
  function automatic logic state_is_dark(input led_state_e s);
    return (s == ST_NO_LINK) || (s == ST_BLINK_OFF);
  endfunction

  function automatic logic any_activity(input logic tx, input logic rx);
    return tx | rx;
  endfunction

endpackage

// File: rtl/link_blink_timer.sv
module link_blink_timer #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic load,
  output logic done
);
  localparam int CW = link_blink_pkg::cnt_width(TICKS);
  localparam logic [CW-1:0] LOAD_VAL = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)     cnt <= '0;
    else if (load)        cnt <= LOAD_VAL;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign done = (cnt == '0);

  // R2 / R3: every phase starts from the full interval
  assert_load_full_R2: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> (cnt == LOAD_VAL));

  // R3: counter never leaves its range
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD_VAL);
endmodule

// File: rtl/link_blink_pending.sv
module link_blink_pending (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic arm,
  input  logic act,
  input  logic consume,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst || clear || consume) pending <= 1'b0;
    else if (arm && act)         pending <= 1'b1;
  end

  // R4: the flag only rises from activity in a busy window
  assert_pend_src_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(arm && act));

  // R6: link loss forgets pending activity
  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clear |=> !pending);
endmodule

// File: rtl/link_blink_fsm.sv
module link_blink_fsm
  import link_blink_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic link_up,
  input  logic act,
  input  logic pending,
  input  logic done,
  output logic load,
  output logic consume,
  output logic arm,
  output logic clear_all,
  output logic led_dark
);
  led_state_e st, nxt;

  always_comb begin
    nxt     = st;
    load    = 1'b0;
    consume = 1'b0;
    if (!link_up) begin
      nxt = ST_NO_LINK;
    end else begin
      unique case (st)
        ST_NO_LINK:   nxt = ST_LINK_IDLE;
        ST_LINK_IDLE: if (act) begin
          nxt  = ST_BLINK_OFF;
          load = 1'b1;
        end
        ST_BLINK_OFF: if (done) begin
          nxt  = ST_HOLD_ON;
          load = 1'b1;
        end
        ST_HOLD_ON: if (done) begin
          if (act || pending) begin
            nxt     = ST_BLINK_OFF;
            load    = 1'b1;
            consume = 1'b1;
          end else begin
            nxt = ST_LINK_IDLE;
          end
        end
        default: nxt = ST_NO_LINK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_NO_LINK;
    else     st <= nxt;
  end

  assign arm       = link_up && ((st == ST_BLINK_OFF) || ((st == ST_HOLD_ON) && !done));
  assign clear_all = !link_up;
  assign led_dark  = state_is_dark(st);

  assert_idle_lit_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LINK_IDLE && link_up && !act) |=> !led_dark);

  assert_blink_len_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BLINK_OFF && !done && link_up) |=> (st == ST_BLINK_OFF));

  assert_hold_min_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD_ON && !done && link_up) |=> (st == ST_HOLD_ON));

  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD_ON && done && link_up && act) |=> (st == ST_BLINK_OFF));

  assert_dark_nolink_R6: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> led_dark);
endmodule

// File: rtl/link_blink_led.sv
module link_blink_led #(
  parameter int TICKS_PER_INTERVAL = 2000000
) (
  input  logic clk,
  input  logic rst,
  input  logic link_up_i,
  input  logic tx_act_i,
  input  logic rx_act_i,
  input  logic fdx_i,
  output logic led_link_n_o,
  output logic led_fdx_n_o
);
  logic act, load, consume, arm, clear_all, done, pending, led_dark;
  logic fdx_n_q;

  assign act = link_blink_pkg::any_activity(tx_act_i, rx_act_i);

  link_blink_fsm u_fsm (
    .clk, .rst, .link_up(link_up_i), .act, .pending, .done,
    .load, .consume, .arm, .clear_all, .led_dark
  );

  link_blink_timer #(.TICKS(TICKS_PER_INTERVAL)) u_timer (
    .clk, .rst, .clear(clear_all), .load, .done
  );

  link_blink_pending u_pending (
    .clk, .rst, .clear(clear_all), .arm, .act, .consume, .pending
  );

  always_ff @(posedge clk) begin
    if (rst) fdx_n_q <= 1'b1;
    else     fdx_n_q <= ~(link_up_i & fdx_i);
  end

  assign led_link_n_o = led_dark;
  assign led_fdx_n_o  = fdx_n_q;

  assert_fdx_on_R8: assert property (@(posedge clk) disable iff (rst)
    (link_up_i && fdx_i) |=> !led_fdx_n_o);

  assert_reset_dark_R9: assert property (@(posedge clk)
    rst |=> (led_link_n_o && led_fdx_n_o));
endmodule

// File: tb/link_blink_led_tb.sv
`timescale 1ns/1ps
module link_blink_led_tb;
  localparam int T = 4;

  typedef struct packed {
    logic       link, tx, rx, fdx, exp_led, exp_fdx;
    logic [3:0] req;
  } vec_t;

  // Expected LED levels follow the interval of T=4 ticks.
  localparam vec_t VECS [0:32] = '{
    '{1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1, 4'd1}, // 0  R1 link idle lit
    '{1'b1,1'b1,1'b0,1'b1, 1'b1,1'b0, 4'd2}, // 1  R2 tx -> dark
    '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'd2}, // 2
    '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'd2}, // 3
    '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'd2}, // 4  last dark
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd3}, // 5  R3 hold lit
    '{1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0, 4'd4}, // 6  R4 rx during hold
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd3}, // 7
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd3}, // 8  last hold
    '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'd4}, // 9  pending blink
    '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'd4}, // 10
    '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'd4}, // 11
    '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'd4}, // 12
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd3}, // 13 hold
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd3}, // 14
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd3}, // 15
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd3}, // 16
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd4}, // 17 R4 no pending -> idle
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd1}, // 18
    '{1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0, 4'd2}, // 19 tx+rx -> dark
    '{1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1, 4'd6}, // 20 R6 link lost
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd6}, // 21 link back lit
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd6}, // 22 no leftover blink
    '{1'b1,1'b1,1'b0,1'b1, 1'b1,1'b0, 4'd2}, // 23
    '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'd2}, // 24
    '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'd2}, // 25
    '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0, 4'd2}, // 26
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd3}, // 27
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd3}, // 28
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd3}, // 29
    '{1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd3}, // 30 last hold
    '{1'b1,1'b1,1'b0,1'b1, 1'b1,1'b0, 4'd5}, // 31 R5 strobe at hold end
    '{1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd8}  // 32 R8 fdx off with link
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_up_i = 1'b0, tx_act_i = 1'b0, rx_act_i = 1'b0, fdx_i = 1'b0;
  logic led_link_n_o, led_fdx_n_o;
  int   errors = 0;
  int   checks = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  link_blink_led #(.TICKS_PER_INTERVAL(T)) u_dut (
    .clk, .rst, .link_up_i, .tx_act_i, .rx_act_i, .fdx_i,
    .led_link_n_o, .led_fdx_n_o
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic t, input logic r, input logic f);
    link_up_i = l; tx_act_i = t; rx_act_i = r; fdx_i = f;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int run;
    repeat (3) @(negedge clk);
    chk(led_link_n_o, 1'b1, "R9 reset link led");
    chk(led_fdx_n_o,  1'b1, "R9 reset fdx led");
    rst = 1'b0;

    for (int i = 0; i < 33; i++) begin
      drive(VECS[i].link, VECS[i].tx, VECS[i].rx, VECS[i].fdx);
      @(negedge clk);
      chk(led_link_n_o, VECS[i].exp_led, $sformatf("R%0d vec %0d link led", VECS[i].req, i));
      chk(led_fdx_n_o,  VECS[i].exp_fdx, $sformatf("R8 vec %0d fdx led", i));
    end

    // R7: activity while link is down is ignored
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk(led_link_n_o, 1'b1, "R7 dark without link");
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < T + 3; k++) begin
      @(negedge clk);
      chk(led_link_n_o, 1'b0, "R7 steady lit after link returns");
    end

    // R2: measured dark length of a single strobe
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    run = 0;
    while (led_link_n_o === 1'b1 && run < 4 * T) begin
      run++;
      @(negedge clk);
    end
    chk(run == T, 1'b1, $sformatf("R2 dark length %0d", run));

    // R3: continuous traffic, measured lit length between pulses
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    repeat (2 * T) @(negedge clk);
    while (led_link_n_o === 1'b0) @(negedge clk);
    while (led_link_n_o === 1'b1) @(negedge clk);
    run = 0;
    while (led_link_n_o === 1'b0 && run < 4 * T) begin
      run++;
      @(negedge clk);
    end
    chk(run == T, 1'b1, $sformatf("R3 lit length %0d", run));

    // R9: reset in the middle of a blink clears everything
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    repeat (4 * T) @(negedge clk);
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk(led_link_n_o, 1'b1, "R9 pre-reset blink dark");
    rst = 1'b1;
    @(negedge clk);
    chk(led_link_n_o, 1'b1, "R9 reset mid-blink link led");
    chk(led_fdx_n_o,  1'b1, "R9 reset mid-blink fdx led");
    rst = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk(led_link_n_o, 1'b0, "R9 lit after reset release");
    chk(led_fdx_n_o,  1'b0, "R8 fdx lit after reset release");
    for (int k = 0; k < T + 2; k++) begin
      @(negedge clk);
      chk(led_link_n_o, 1'b0, "R9 no pending blink after reset");
    end

    finish_run();
  end
endmodule